// File: doc/BRIEF.md
# Buffered I2C Master Command Engine

The engine runs one whole I2C transaction, write or read, from a small byte buffer held in register space. Software first loads the slave address byte at buffer slot 0. This byte is the 7-bit address shifted up by one, with bit 0 set to 1 for a read. Software then loads the payload at the following slots, or zeros as placeholders for a read. A single control write then launches the transaction and gives the total number of buffer bytes to move, the address byte included.

The engine issues a START and shifts the bytes out MSB first. It samples the slave's acknowledge after each byte it sends. On a read, it clocks the incoming bytes back into the buffer over the placeholders. It closes with a STOP and leaves a two-bit result in the status register. The bus pins are open-drain: each output asks for its line to be pulled low, and a released line reads high through the pull-up. A divider derives the SCL rate from the core clock. The default is 100 kHz from 200 MHz. Arbitration between masters and clock stretching are not handled.

Register map (`host_addr`): 0 is control (write only, reads 0), 1 is status, and `BUF_DEPTH` + i is buffer slot i (top address bit set).

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset the status field (status register bits 7:6) reads 00, and neither SCL nor SDA is pulled low.
- R2: A control write with bit 7 set and a count N in bits 6:0, where 1 <= N <= BUF_DEPTH, starts a transaction with a START: SDA falls while SCL is high. A control write with bit 7 set and N = 0 or N > BUF_DEPTH is ignored.
- R3: Bytes go on the bus in slot order 0 to N-1, each MSB first. Bit 0 of slot 0 selects the direction, and 1 means read.
- R4: After each byte the master sends, it releases SDA for the acknowledge bit. If SDA is high then, the status becomes 10, a STOP follows at once and no further byte is clocked.
- R5: On a read, slots 1 to N-1 are received MSB first and written back into those slots. The master pulls SDA low in the acknowledge bit of every received byte except the last, which it leaves high.
- R6: SDA changes only while SCL is low, except in START and STOP. Each transaction ends with exactly one STOP, where SDA rises while SCL is high.
- R7: The status field reads 00 while a transaction runs, and 01 after a transaction that ends without a NACK.
- R8: While a transaction runs, further control writes and host writes to the buffer have no effect.
- R9: Writing 0x00 to control while idle clears the status field to 00.
- R10: SCL is high for 2*QUARTER clock cycles per bit, where QUARTER = CLK_HZ/(4*SCL_HZ).
- R11: A transaction of 50 bytes (address plus 49 payload bytes) runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | IDX_W+1 | Host register address (control, status, buffer slots) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr (combinational) |
| sda_in | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The assertions take it that QUARTER is at least 2. With that, every quarter of a bit lasts long enough for the registered SCL drive to settle before SDA is sampled. They also take it that the slave model moves SDA only just after SCL falls. The bench slave changes its pull only on the clock edge after it sees SCL go low. It releases SDA after the master NACKs its last byte. It also releases SDA in any acknowledge bit it means to refuse. Host writes during a transaction come only from the deliberate R8 stimulus, and the assertions treat them as blocked.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_START,
    SEQ_BIT,
    SEQ_ACK,
    SEQ_STOP
  } seq_state_e;

  localparam logic [1:0] STAT_CLEAR = 2'b00;
  localparam logic [1:0] STAT_OK    = 2'b01;
  localparam logic [1:0] STAT_FAIL  = 2'b10;

  localparam int CTRL_GO_BIT = 7;

endpackage

// File: rtl/i2c_cmd_tick.sv
module i2c_cmd_tick #(
  parameter int QUARTER = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);

  localparam int CNT_W = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(QUARTER - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == '0);

  always_comb begin
    if (!en_i || cnt_q == '0) cnt_d = RELOAD;
    else                      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  generate
    if (QUARTER > 1) begin : g_tick_chk
      // quarter steps are never back to back (R10)
      assert_tick_spaced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
  import i2c_cmd_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int IDX_W     = 6,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              fail_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [7:0]        byte_o,
  input  logic              cap_we_i,
  input  logic [IDX_W-1:0]  cap_idx_i,
  input  logic [7:0]        cap_data_i,
  output logic              start_o,
  output logic [IDX_W-1:0]  last_o
);

  localparam logic [7:0] DEPTH_B = 8'(BUF_DEPTH);

  logic [7:0]       buf_q [BUF_DEPTH];
  logic [1:0]       stat_q, stat_d;
  logic             sel_ctrl, sel_stat, sel_buf;
  logic [IDX_W-1:0] host_idx;
  logic [6:0]       cnt;
  logic             cnt_ok, clear;

  assign sel_ctrl = (host_addr == ADDR_W'(0));
  assign sel_stat = (host_addr == ADDR_W'(1));
  assign sel_buf  = host_addr[ADDR_W-1];
  assign host_idx = host_addr[IDX_W-1:0];
  assign cnt      = host_wdata[6:0];
  assign cnt_ok   = (cnt != 7'd0) && ({1'b0, cnt} <= DEPTH_B);
  assign start_o  = host_we && sel_ctrl && host_wdata[CTRL_GO_BIT] && cnt_ok && !busy_i;
  assign clear    = host_we && sel_ctrl && (host_wdata == 8'h00) && !busy_i;
  assign last_o   = IDX_W'(cnt - 7'd1);

  // status next state
  always_comb begin
    stat_d = stat_q;
    if (start_o)     stat_d = STAT_CLEAR;
    else if (done_i) stat_d = fail_i ? STAT_FAIL : STAT_OK;
    else if (clear)  stat_d = STAT_CLEAR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_CLEAR;
    else        stat_q <= stat_d;
  end

  // byte buffer, one enable per slot; host blocked while busy
  generate
    for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_slot
      logic       host_hit, cap_hit, slot_en;
      logic [7:0] slot_d;
      assign host_hit = host_we && sel_buf && !busy_i && (host_idx == IDX_W'(g));
      assign cap_hit  = cap_we_i && (cap_idx_i == IDX_W'(g));
      assign slot_en  = host_hit || cap_hit;
      assign slot_d   = cap_hit ? cap_data_i : host_wdata;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       buf_q[g] <= 8'h00;
        else if (slot_en) buf_q[g] <= slot_d;
      end
    end
  endgenerate

  assign byte_o = buf_q[rd_idx_i];

  always_comb begin
    host_rdata = 8'h00;
    if (sel_stat) host_rdata = {stat_q, 6'b000000};
    else if (sel_buf && ({1'b0, host_idx} < (IDX_W+1)'(BUF_DEPTH)))
      host_rdata = buf_q[host_idx];
  end

  // result field stays clear for the whole transaction (R7)
  assert_stat_clear_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (stat_q == STAT_CLEAR));

  // host buffer write during a transaction leaves the slot alone (R8)
  assert_host_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && host_we && sel_buf && !cap_we_i) |=>
      (buf_q[$past(host_idx)] == $past(buf_q[host_idx])));

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_cmd_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic [7:0]       byte_i,
  input  logic             sda_in_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             cap_we_o,
  output logic [IDX_W-1:0] cap_idx_o,
  output logic [7:0]       cap_data_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             scl_low_o,
  output logic             sda_low_o
);

  seq_state_e       state_q, state_d;
  logic [1:0]       q_q, q_d;
  logic [2:0]       bit_q, bit_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q, last_d;
  logic [7:0]       shift_q, shift_d;
  logic             rd_mode_q, rd_mode_d, err_q, err_d;
  logic             scl_low_q, scl_low_d, sda_low_q, sda_low_d;
  logic             receiving;

  assign receiving  = rd_mode_q && (idx_q != '0);
  assign busy_o     = (state_q != SEQ_IDLE);
  assign rd_idx_o   = (state_q == SEQ_ACK) ? idx_q + 1'b1 : idx_q;
  assign cap_idx_o  = idx_q;
  assign cap_data_o = shift_q;
  assign fail_o     = err_q;
  assign scl_low_o  = scl_low_q;
  assign sda_low_o  = sda_low_q;

  // next state
  always_comb begin
    state_d   = state_q;
    q_d       = q_q;
    bit_d     = bit_q;
    idx_d     = idx_q;
    last_d    = last_q;
    shift_d   = shift_q;
    rd_mode_d = rd_mode_q;
    err_d     = err_q;
    cap_we_o  = 1'b0;
    done_o    = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = SEQ_START;
          q_d     = 2'd0;
          idx_d   = '0;
          last_d  = last_i;
          err_d   = 1'b0;
        end
      end
      SEQ_START: begin
        if (tick_i) begin
          if (q_q == 2'd3) begin
            state_d   = SEQ_BIT;
            q_d       = 2'd0;
            bit_d     = 3'd7;
            shift_d   = byte_i;
            rd_mode_d = byte_i[0];
          end else begin
            q_d = q_q + 2'd1;
          end
        end
      end
      SEQ_BIT: begin
        if (tick_i) begin
          if (q_q == 2'd2 && receiving) shift_d = {shift_q[6:0], sda_in_i};
          if (q_q == 2'd3) begin
            q_d = 2'd0;
            if (bit_q == 3'd0) begin
              state_d = SEQ_ACK;
            end else begin
              bit_d = bit_q - 3'd1;
              if (!receiving) shift_d = {shift_q[6:0], 1'b0};
            end
          end else begin
            q_d = q_q + 2'd1;
          end
        end
      end
      SEQ_ACK: begin
        if (tick_i) begin
          if (q_q == 2'd2) begin
            if (receiving)     cap_we_o = 1'b1;
            else if (sda_in_i) err_d    = 1'b1;
          end
          if (q_q == 2'd3) begin
            q_d = 2'd0;
            if (err_q || idx_q == last_q) begin
              state_d = SEQ_STOP;
            end else begin
              state_d = SEQ_BIT;
              idx_d   = idx_q + 1'b1;
              bit_d   = 3'd7;
              shift_d = byte_i;
            end
          end else begin
            q_d = q_q + 2'd1;
          end
        end
      end
      SEQ_STOP: begin
        if (tick_i) begin
          if (q_q == 2'd3) begin
            state_d = SEQ_IDLE;
            q_d     = 2'd0;
            idx_d   = '0;
            done_o  = 1'b1;
          end else begin
            q_d = q_q + 2'd1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // line drive; SDA holds during the first quarter after SCL falls
  always_comb begin
    scl_low_d = 1'b0;
    sda_low_d = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        scl_low_d = 1'b0;
        sda_low_d = 1'b0;
      end
      SEQ_START: begin
        scl_low_d = (q_q == 2'd3);
        sda_low_d = (q_q >= 2'd2);
      end
      SEQ_BIT: begin
        scl_low_d = (q_q < 2'd2);
        sda_low_d = (q_q == 2'd0) ? sda_low_q : (!receiving && !shift_q[7]);
      end
      SEQ_ACK: begin
        scl_low_d = (q_q < 2'd2);
        sda_low_d = (q_q == 2'd0) ? sda_low_q : (receiving && idx_q != last_q);
      end
      SEQ_STOP: begin
        scl_low_d = (q_q < 2'd2);
        sda_low_d = (q_q == 2'd0) ? sda_low_q : (q_q != 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      q_q       <= 2'd0;
      bit_q     <= 3'd7;
      idx_q     <= '0;
      last_q    <= '0;
      shift_q   <= 8'h00;
      rd_mode_q <= 1'b0;
      err_q     <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      q_q       <= q_d;
      bit_q     <= bit_d;
      idx_q     <= idx_d;
      last_q    <= last_d;
      shift_q   <= shift_d;
      rd_mode_q <= rd_mode_d;
      err_q     <= err_d;
      scl_low_q <= scl_low_d;
      sda_low_q <= sda_low_d;
    end
  end

  // SDA moves under a high SCL only for START or STOP (R6)
  assert_sda_steady_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_low_q != $past(sda_low_q)) && !scl_low_q && !$past(scl_low_q)) |->
      ($past(state_q) == SEQ_START || $past(state_q) == SEQ_STOP));

  // after a NACK no further byte is clocked (R4)
  assert_no_bits_after_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && state_q != SEQ_IDLE) |-> (state_q == SEQ_ACK || state_q == SEQ_STOP));

  // byte index never passes the programmed count (R3)
  assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (idx_q <= last_q));

  // received bytes: ACK low except on the last one (R5)
  assert_read_ack_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_ACK && q_q == 2'd2 && rd_mode_q && idx_q != '0) |->
      (sda_low_q == (idx_q != last_q)));

endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine #(
  parameter int  CLK_HZ    = 200_000_000,
  parameter int  SCL_HZ    = 100_000,
  parameter int  BUF_DEPTH = 64,
  localparam int IDX_W     = $clog2(BUF_DEPTH),
  localparam int ADDR_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);

  localparam int QUARTER = CLK_HZ / (4 * SCL_HZ);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_i;
  logic             tick, busy, done, fail, start, cap_we;
  logic [IDX_W-1:0] last, rd_idx, cap_idx;
  logic [7:0]       cur_byte, cap_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  i2c_cmd_tick #(.QUARTER(QUARTER)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .en_i   (busy),
    .tick_o (tick)
  );

  i2c_cmd_regs #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy_i     (busy),
    .done_i     (done),
    .fail_i     (fail),
    .rd_idx_i   (rd_idx),
    .byte_o     (cur_byte),
    .cap_we_i   (cap_we),
    .cap_idx_i  (cap_idx),
    .cap_data_i (cap_data),
    .start_o    (start),
    .last_o     (last)
  );

  i2c_cmd_seq #(.IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .tick_i     (tick),
    .start_i    (start),
    .last_i     (last),
    .byte_i     (cur_byte),
    .sda_in_i   (sda_in),
    .busy_o     (busy),
    .rd_idx_o   (rd_idx),
    .cap_we_o   (cap_we),
    .cap_idx_o  (cap_idx),
    .cap_data_o (cap_data),
    .done_o     (done),
    .fail_o     (fail),
    .scl_low_o  (scl_drive_low),
    .sda_low_o  (sda_drive_low)
  );

endmodule

// File: tb/test_i2c_cmd_engine.sv
`timescale 1ns/1ps
module test_i2c_cmd_engine;

  localparam int CLK_HZ = 200_000_000;
  localparam int SCL_HZ = 10_000_000;
  localparam int DEPTH  = 64;
  localparam int QTR    = CLK_HZ / (4 * SCL_HZ);

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_we;
  logic [6:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       scl_drive_low, sda_drive_low;
  logic       slave_pull;
  wire        sda_line = ~(sda_drive_low | slave_pull);
  wire        scl_line = ~scl_drive_low;

  always #2.5 clk = ~clk;

  i2c_cmd_engine #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .BUF_DEPTH(DEPTH)) i_i2c_cmd_engine (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_we       (host_we),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .sda_in        (sda_line),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard: expected bus items (kind 0 = byte seen by slave, 1 = master ack bit)
  typedef struct {
    bit         is_ack;
    logic [7:0] val;
    string      req;
  } sb_item_t;
  sb_item_t exp_q[$];

  task automatic expect_byte(input logic [7:0] v, input string req);
    sb_item_t it;
    it.is_ack = 1'b0; it.val = v; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic expect_ack(input logic a, input string req);
    sb_item_t it;
    it.is_ack = 1'b1; it.val = {7'd0, a}; it.req = req;
    exp_q.push_back(it);
  endtask

  function automatic logic [7:0] rd_byte(input int i);
    return 8'((i * 37) + 5);
  endfunction

  task automatic observe(input bit is_ack, input logic [7:0] v);
    sb_item_t it;
    if (exp_q.size() == 0) begin
      check(1'b0, "R3", is_ack ? "unexpected ack bit" : "unexpected byte", v, 0);
    end else begin
      it = exp_q.pop_front();
      check(it.is_ack == is_ack && it.val == v, it.req,
            is_ack ? "master ack bit" : "byte on bus", v, it.val);
    end
  endtask

  // slave model and bus monitor, sampled away from the active edge
  int         nack_at;
  int         bitcnt, byte_i, starts, stops, hi_len, hi_min, hi_max;
  bit         active, is_read, tx_done, seen_rise;
  logic [7:0] rx;
  logic       p_scl, p_sda;

  always @(negedge clk) begin
    logic       scl, sda;
    logic [7:0] d;
    if (!rst_n) begin
      slave_pull = 1'b0; active = 0; p_scl = 1'b1; p_sda = 1'b1;
      bitcnt = 0; byte_i = 0; starts = 0; stops = 0; seen_rise = 0;
      hi_len = 0; hi_min = 1_000_000; hi_max = 0; tx_done = 0; is_read = 0;
    end else begin
      scl = scl_line;
      sda = sda_line;
      if (scl && p_scl) hi_len++;
      if (p_scl && scl && p_sda && !sda) begin
        starts++; active = 1; bitcnt = 0; byte_i = 0; is_read = 0;
        tx_done = 0; seen_rise = 0; slave_pull = 1'b0;
      end else if (p_scl && scl && !p_sda && sda) begin
        stops++; active = 0; slave_pull = 1'b0;
      end else if (active && !p_scl && scl) begin
        seen_rise = 1; hi_len = 1;
        bitcnt++;
        if (bitcnt <= 8) begin
          if (!(is_read && byte_i > 0)) rx = {rx[6:0], sda};
        end else if (is_read && byte_i > 0) begin
          observe(1'b1, {7'd0, sda});
          if (sda) tx_done = 1;
        end
      end else if (active && p_scl && !scl) begin
        if (seen_rise) begin
          if (hi_len < hi_min) hi_min = hi_len;
          if (hi_len > hi_max) hi_max = hi_len;
        end
        if (bitcnt >= 1 && bitcnt <= 7) begin
          if (is_read && byte_i > 0 && !tx_done) begin
            d = rd_byte(byte_i);
            slave_pull = ~d[7 - bitcnt];
          end
        end else if (bitcnt == 8) begin
          if (!(is_read && byte_i > 0)) begin
            observe(1'b0, rx);
            if (byte_i == 0) is_read = rx[0];
            slave_pull = (byte_i != nack_at);
          end else begin
            slave_pull = 1'b0;
          end
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          byte_i++;
          if (is_read && !tx_done) begin
            d = rd_byte(byte_i);
            slave_pull = ~d[7];
          end else begin
            slave_pull = 1'b0;
          end
        end
      end
      p_scl = scl;
      p_sda = sda;
    end
  end

  // host access
  task automatic host_write(input logic [6:0] a, input logic [7:0] v);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [6:0] a, output logic [7:0] v);
    @(negedge clk);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = 8'h00;
    for (int i = 0; i < 40000; i++) begin
      host_read(7'd1, st);
      if (st[7:6] != 2'b00) break;
    end
  endtask

  localparam logic [6:0] BUFA = 7'h40;

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] st, v;
    int s0, p0;
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0; nack_at = -1;
    repeat (3) @(negedge clk);
    check(!scl_drive_low && !sda_drive_low, "R1", "lines released in reset",
          {scl_drive_low, sda_drive_low}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    host_read(7'd1, st);
    check(st[7:6] == 2'b00, "R1", "status after reset", st, 8'h00);

    // write of 3 bytes, with blocked writes while busy
    host_write(BUFA + 7'd0, 8'hA0);
    host_write(BUFA + 7'd1, 8'h12);
    host_write(BUFA + 7'd2, 8'h34);
    expect_byte(8'hA0, "R3"); expect_byte(8'h12, "R3"); expect_byte(8'h34, "R3");
    s0 = starts; p0 = stops;
    host_write(7'd0, 8'h83);
    host_read(7'd1, st);
    check(st[7:6] == 2'b00, "R7", "status while busy", st, 8'h00);
    host_write(7'd0, 8'h81);
    host_write(BUFA + 7'd1, 8'hEE);
    wait_done(st);
    check(st == 8'h40, "R7", "status after good write", st, 8'h40);
    host_read(BUFA + 7'd1, v);
    check(v == 8'h12, "R8", "slot 1 after busy write", v, 8'h12);
    check(exp_q.size() == 0, "R8", "items left after write", exp_q.size(), 0);
    check(starts == s0 + 1, "R2", "START count", starts - s0, 1);
    check(stops == p0 + 1, "R6", "STOP count", stops - p0, 1);
    check(hi_min == 2 * QTR && hi_max == 2 * QTR, "R10", "SCL high length",
          hi_max, 2 * QTR);

    // read of 4 bytes
    host_write(BUFA + 7'd0, 8'hA1);
    for (int i = 1; i <= 4; i++) host_write(BUFA + 7'(i), 8'h00);
    expect_byte(8'hA1, "R3");
    expect_ack(1'b0, "R5"); expect_ack(1'b0, "R5"); expect_ack(1'b0, "R5");
    expect_ack(1'b1, "R5");
    host_write(7'd0, 8'h85);
    host_read(7'd1, st);
    check(st[7:6] == 2'b00, "R7", "status cleared at start", st, 8'h00);
    wait_done(st);
    check(st == 8'h40, "R7", "status after read", st, 8'h40);
    for (int i = 1; i <= 4; i++) begin
      host_read(BUFA + 7'(i), v);
      check(v == rd_byte(i), "R5", "captured read byte", v, rd_byte(i));
    end
    check(exp_q.size() == 0, "R5", "items left after read", exp_q.size(), 0);

    // NACK on address
    nack_at = 0;
    host_write(BUFA + 7'd0, 8'hA0);
    expect_byte(8'hA0, "R4");
    p0 = stops;
    host_write(7'd0, 8'h83);
    wait_done(st);
    check(st == 8'h80, "R4", "status after address NACK", st, 8'h80);
    check(stops == p0 + 1, "R4", "STOP after address NACK", stops - p0, 1);
    check(exp_q.size() == 0, "R4", "items left after NACK", exp_q.size(), 0);

    // NACK on payload byte 2 of 4
    nack_at = 2;
    for (int i = 0; i < 4; i++) host_write(BUFA + 7'(i), (i == 0) ? 8'hA0 : 8'(8'h60 + i));
    expect_byte(8'hA0, "R4"); expect_byte(8'h61, "R4"); expect_byte(8'h62, "R4");
    host_write(7'd0, 8'h84);
    wait_done(st);
    check(st == 8'h80, "R4", "status after data NACK", st, 8'h80);
    check(exp_q.size() == 0, "R4", "items left after data NACK", exp_q.size(), 0);
    nack_at = -1;

    // clear with control 0
    host_write(7'd0, 8'h00);
    host_read(7'd1, st);
    check(st == 8'h00, "R9", "status after clear", st, 8'h00);

    // invalid counts ignored
    s0 = starts;
    host_write(7'd0, 8'h80);
    host_write(7'd0, 8'hFF);
    repeat (60) @(negedge clk);
    check(starts == s0 && !scl_drive_low, "R2", "START on invalid count", starts - s0, 0);
    host_read(7'd1, st);
    check(st == 8'h00, "R2", "status after invalid count", st, 8'h00);

    // long write: address plus 49 payload bytes
    host_write(BUFA + 7'd0, 8'hA0);
    expect_byte(8'hA0, "R11");
    for (int i = 1; i < 50; i++) begin
      host_write(BUFA + 7'(i), 8'(i * 3 + 1));
      expect_byte(8'(i * 3 + 1), "R11");
    end
    host_write(7'd0, 8'hB2);
    wait_done(st);
    check(st == 8'h40, "R11", "status after long write", st, 8'h40);
    check(exp_q.size() == 0, "R11", "items left after long write", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule